// File: doc/BRIEF.md
# Oldest-First Multi-Class Issue Selector

The selector sits between a set of per-operation-class ready queues and the execute stage. Each class queue presents only its oldest ready entry: a valid flag, a sequence number, a squash flag and a thread id. Every cycle the selector ranks the valid classes by the age of their heads, with a smaller sequence number meaning older. It then walks them from oldest to youngest. The walk grants an issue slot whenever the class's functional unit is free, and it pops squashed heads without charging them any issue bandwidth. A class whose unit is busy is passed over and charged one busy event. The walk stops once it has granted the issue width, or the number of free downstream slots if that is smaller. Sequence numbers are unique, so the ranking never ties.

Class index `NOUNIT` stands for operations that need no functional unit. These issue whatever the unit-free input says and never produce a release. For every other class the selector takes the operation latency and issue latency of its unit and decides how the unit is released. A single-cycle or pipelined unit is released, and the operation handed to execute, one cycle after the grant. An unpipelined multi-cycle unit stays held inside the selector, and both the hand-off and the release come `iss_lat` cycles after the grant.

The order is recomputed from the current heads every cycle. A popped class is therefore re-ranked by its new head, and a new older arrival moves its class forward at once.

Top module: `issue_select`

## Requirements
- R1: In one cycle the number of bits set in `grant_o` never exceeds min(`WIDTH`, `ds_slots`), and `n_grant_o` equals that number.
- R2: The granted classes are the oldest eligible classes, taken in ascending head sequence number. A class is eligible when it is valid, not squashed, and has its unit available. Its unit is available if the class is `NOUNIT`, or if `unit_free` is 1 and the class is not held.
- R3: A valid squashed head that the walk reaches before the budget is used up has its `pop_o` bit set and its `grant_o` bit clear, and it does not reduce the number of grants left for younger classes. Every granted class also has its `pop_o` bit set.
- R4: A valid, unsquashed head whose unit is unavailable, and which the walk reaches before the budget is used up, gets `skip_o` set and neither grant nor pop. On the next clock edge its busy counter for (class, head thread) rises by one, saturating at 2^`BCW`-1. Counter (c,t) sits at `busy_cnt_o[(c*NTHR+t)*BCW +: BCW]`.
- R5: The `NOUNIT` class issues even when its `unit_free` bit is 0, and its `rel_o` bit never rises.
- R6: A grant to the `NOUNIT` class, or to a class with `op_lat` <= 1 or `iss_lat` <= 1, raises `exec_o` for that class in the next cycle. For classes other than `NOUNIT`, `rel_o` also rises in that cycle.
- R7: A grant to any other class with `op_lat` > 1 and `iss_lat` > 1 holds that class. Both `exec_o` and `rel_o` for it rise exactly `iss_lat` cycles after the grant, and the class cannot be granted while it is held.
- R8: With `ds_slots` = 0 no class is visited: `grant_o`, `pop_o` and `skip_o` are all zero, and no busy counter changes.
- R9: A class with `head_vld` = 0 never gets grant, pop or skip.
- R10: While reset is held, `exec_o`, `rel_o` and all busy counters are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| head_vld | input | NCLS | Class queue has a ready head |
| head_seq | input | NCLS*SEQW | Head sequence number per class |
| head_sq | input | NCLS | Head is squashed |
| head_tid | input | NCLS*TIDW | Thread of the head |
| unit_free | input | NCLS | A unit of that class is free this cycle |
| op_lat | input | NCLS*LATW | Operation latency per class |
| iss_lat | input | NCLS*LATW | Issue latency per class (1 = pipelined) |
| ds_slots | input | GW | Slots the downstream stage can accept this cycle |
| grant_o | output | NCLS | Head of class issues this cycle |
| pop_o | output | NCLS | Remove head of class (issued or squashed) |
| skip_o | output | NCLS | Class visited but its unit was unavailable |
| n_grant_o | output | GW | Number of grants this cycle |
| exec_o | output | NCLS | Operation of class handed to execute |
| rel_o | output | NCLS | Release request for the class's unit |
| busy_cnt_o | output | NCLS*NTHR*BCW | Busy-event counters per class and thread |

## Verification
Random heads with unique sequence numbers are mixed with random squash flags, unit availability, latencies and slot counts. This checks that the grants follow age order rather than class index, and that squashed heads leave the budget untouched. Directed cycles give all classes free units and plenty of slots, then zero slots, then only squashed heads. These separate the three stopping conditions of the walk. Further directed cycles offer the unit-less class with its unit-free bit low, and an unpipelined class that is offered again while it is held. These tell the held path apart from the next-cycle release path and show when the busy counter rises.

// File: rtl/issue_select_pkg.sv
package issue_select_pkg;

    typedef enum logic [1:0] {
        REL_NONE = 2'd0,
        REL_NEXT = 2'd1,
        REL_HOLD = 2'd2
    } rel_kind_e;

    function automatic rel_kind_e rel_kind(input logic no_unit,
                                           input logic op_multi,
                                           input logic iss_multi);
        if (no_unit)
            return REL_NONE;
        else if (op_multi && iss_multi)
            return REL_HOLD;
        else
            return REL_NEXT;
    endfunction

endpackage

// File: rtl/issue_select_rank.sv
module issue_select_rank #(
    parameter int NCLS = 4,
    parameter int SEQW = 8,
    parameter int RW   = 2
) (
    input  logic [NCLS-1:0]      vld,
    input  logic [NCLS*SEQW-1:0] seq,
    output logic [NCLS*RW-1:0]   rank
);

    for (genvar c = 0; c < NCLS; c++) begin : g_cls
        logic [RW-1:0] older_cnt;
        always_comb begin
            older_cnt = '0;
            for (int j = 0; j < NCLS; j++) begin
                if (j != c && vld[j] &&
                    seq[j*SEQW +: SEQW] < seq[c*SEQW +: SEQW])
                    older_cnt = older_cnt + 1'b1;
            end
        end
        assign rank[c*RW +: RW] = older_cnt;
    end

endmodule

// File: rtl/issue_select_pick.sv
module issue_select_pick #(
    parameter int NCLS  = 4,
    parameter int RW    = 2,
    parameter int GW    = 2
) (
    input  logic [NCLS-1:0]    vld,
    input  logic [NCLS-1:0]    sq,
    input  logic [NCLS-1:0]    avail,
    input  logic [NCLS*RW-1:0] rank,
    input  logic [GW-1:0]      budget,
    output logic [NCLS-1:0]    grant,
    output logic [NCLS-1:0]    pop,
    output logic [NCLS-1:0]    skip,
    output logic [GW-1:0]      n_grant
);

    always_comb begin
        logic          stop;
        logic [GW-1:0] used;
        grant = '0;
        pop   = '0;
        skip  = '0;
        used  = '0;
        stop  = (budget == '0);
        for (int k = 0; k < NCLS; k++) begin
            for (int c = 0; c < NCLS; c++) begin
                if (vld[c] && rank[c*RW +: RW] == RW'(k) && !stop) begin
                    if (sq[c]) begin
                        pop[c] = 1'b1;
                    end else if (avail[c]) begin
                        grant[c] = 1'b1;
                        pop[c]   = 1'b1;
                        used     = used + 1'b1;
                        if (used == budget)
                            stop = 1'b1;
                    end else begin
                        skip[c] = 1'b1;
                    end
                end
            end
        end
        n_grant = used;
    end

endmodule

// File: rtl/issue_select_unit.sv
module issue_select_unit
    import issue_select_pkg::*;
#(
    parameter int NCLS   = 4,
    parameter int LATW   = 3,
    parameter int NOUNIT = 0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NCLS-1:0]      grant,
    input  logic [NCLS*LATW-1:0] op_lat,
    input  logic [NCLS*LATW-1:0] iss_lat,
    output logic [NCLS-1:0]      held,
    output logic [NCLS-1:0]      exec_o,
    output logic [NCLS-1:0]      rel_o
);

    typedef struct packed {
        logic [NCLS*LATW-1:0] tmr;
        logic [NCLS-1:0]      exec;
        logic [NCLS-1:0]      rel;
    } unit_st_t;

    unit_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.exec = '0;
        st_d.rel  = '0;
        for (int c = 0; c < NCLS; c++) begin
            logic [LATW-1:0] t;
            rel_kind_e       kind;
            t = st_q.tmr[c*LATW +: LATW];
            if (t != '0) begin
                st_d.tmr[c*LATW +: LATW] = t - 1'b1;
                if (t == LATW'(1)) begin
                    st_d.exec[c] = 1'b1;
                    st_d.rel[c]  = 1'b1;
                end
            end
            kind = rel_kind(c == NOUNIT,
                            op_lat[c*LATW +: LATW] > LATW'(1),
                            iss_lat[c*LATW +: LATW] > LATW'(1));
            if (grant[c]) begin
                case (kind)
                    REL_NONE: st_d.exec[c] = 1'b1;
                    REL_NEXT: begin
                        st_d.exec[c] = 1'b1;
                        st_d.rel[c]  = 1'b1;
                    end
                    default:
                        st_d.tmr[c*LATW +: LATW] = iss_lat[c*LATW +: LATW] - 1'b1;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    for (genvar c = 0; c < NCLS; c++) begin : g_held
        assign held[c] = (st_q.tmr[c*LATW +: LATW] != '0);
    end

    assign exec_o = st_q.exec;
    assign rel_o  = st_q.rel;

endmodule

// File: rtl/issue_select.sv
module issue_select #(
    parameter int NCLS   = 4,
    parameter int WIDTH  = 2,
    parameter int SEQW   = 8,
    parameter int LATW   = 3,
    parameter int NTHR   = 2,
    parameter int BCW    = 8,
    parameter int NOUNIT = 0,
    parameter int TIDW   = (NTHR > 1) ? $clog2(NTHR) : 1,
    parameter int GW     = $clog2(WIDTH + 1)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NCLS-1:0]           head_vld,
    input  logic [NCLS*SEQW-1:0]      head_seq,
    input  logic [NCLS-1:0]           head_sq,
    input  logic [NCLS*TIDW-1:0]      head_tid,
    input  logic [NCLS-1:0]           unit_free,
    input  logic [NCLS*LATW-1:0]      op_lat,
    input  logic [NCLS*LATW-1:0]      iss_lat,
    input  logic [GW-1:0]             ds_slots,
    output logic [NCLS-1:0]           grant_o,
    output logic [NCLS-1:0]           pop_o,
    output logic [NCLS-1:0]           skip_o,
    output logic [GW-1:0]             n_grant_o,
    output logic [NCLS-1:0]           exec_o,
    output logic [NCLS-1:0]           rel_o,
    output logic [NCLS*NTHR*BCW-1:0]  busy_cnt_o
);

    localparam int RW   = (NCLS > 1) ? $clog2(NCLS) : 1;
    localparam int NBC  = NCLS * NTHR;

    logic [NCLS*RW-1:0] rank;
    logic [NCLS-1:0]    held;
    logic [NCLS-1:0]    avail;
    logic [GW-1:0]      budget;

    issue_select_rank #(.NCLS(NCLS), .SEQW(SEQW), .RW(RW)) u_rank (
        .vld  (head_vld),
        .seq  (head_seq),
        .rank (rank)
    );

    for (genvar c = 0; c < NCLS; c++) begin : g_avail
        if (c == NOUNIT) begin : g_free
            assign avail[c] = 1'b1;
        end else begin : g_unit
            assign avail[c] = unit_free[c] && !held[c];
        end
    end

    assign budget = (ds_slots < GW'(WIDTH)) ? ds_slots : GW'(WIDTH);

    issue_select_pick #(.NCLS(NCLS), .RW(RW), .GW(GW)) u_pick (
        .vld     (head_vld),
        .sq      (head_sq),
        .avail   (avail),
        .rank    (rank),
        .budget  (budget),
        .grant   (grant_o),
        .pop     (pop_o),
        .skip    (skip_o),
        .n_grant (n_grant_o)
    );

    issue_select_unit #(.NCLS(NCLS), .LATW(LATW), .NOUNIT(NOUNIT)) u_unit (
        .clk     (clk),
        .rst_n   (rst_n),
        .grant   (grant_o),
        .op_lat  (op_lat),
        .iss_lat (iss_lat),
        .held    (held),
        .exec_o  (exec_o),
        .rel_o   (rel_o)
    );

    typedef struct packed {
        logic [NBC*BCW-1:0] busy;
    } cnt_st_t;

    cnt_st_t cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        for (int c = 0; c < NCLS; c++) begin
            for (int t = 0; t < NTHR; t++) begin
                if (skip_o[c] && head_tid[c*TIDW +: TIDW] == TIDW'(t) &&
                    cnt_q.busy[(c*NTHR+t)*BCW +: BCW] != {BCW{1'b1}})
                    cnt_d.busy[(c*NTHR+t)*BCW +: BCW] =
                        cnt_q.busy[(c*NTHR+t)*BCW +: BCW] + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else
            cnt_q <= cnt_d;
    end

    assign busy_cnt_o = cnt_q.busy;

endmodule

// File: rtl/issue_select_chk.sv
module issue_select_chk #(
    parameter int NCLS   = 4,
    parameter int WIDTH  = 2,
    parameter int LATW   = 3,
    parameter int NOUNIT = 0,
    parameter int GW     = 2
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [NCLS-1:0]      head_vld,
    input logic [NCLS-1:0]      head_sq,
    input logic [NCLS*LATW-1:0] op_lat,
    input logic [NCLS*LATW-1:0] iss_lat,
    input logic [GW-1:0]        ds_slots,
    input logic [NCLS-1:0]      grant_o,
    input logic [NCLS-1:0]      pop_o,
    input logic [NCLS-1:0]      skip_o,
    input logic [NCLS-1:0]      exec_o,
    input logic [NCLS-1:0]      rel_o
);

    assert_grant_width_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(grant_o) <= WIDTH && $countones(grant_o) <= int'(ds_slots));

    assert_grant_pops_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((grant_o & ~pop_o) == '0) && ((grant_o & head_sq) == '0));

    assert_skip_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (skip_o & (pop_o | head_sq)) == '0);

    assert_nounit_no_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !rel_o[NOUNIT]);

    assert_no_slots_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ds_slots == '0 |-> (pop_o == '0 && skip_o == '0));

    assert_invalid_untouched_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((pop_o | skip_o) & ~head_vld) == '0);

    for (genvar c = 0; c < NCLS; c++) begin : g_lat
        logic quick;
        assign quick = (c == NOUNIT) || (op_lat[c*LATW +: LATW] <= LATW'(1)) ||
                       (iss_lat[c*LATW +: LATW] <= LATW'(1));

        assert_quick_exec_R6: assert property (@(posedge clk) disable iff (!rst_n)
            grant_o[c] && quick |=> exec_o[c]);

        assert_held_no_early_R7: assert property (@(posedge clk) disable iff (!rst_n)
            grant_o[c] && !quick |=> (!exec_o[c] && !rel_o[c] && !grant_o[c]));
    end

endmodule

bind issue_select issue_select_chk #(
    .NCLS(NCLS), .WIDTH(WIDTH), .LATW(LATW), .NOUNIT(NOUNIT), .GW(GW)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .head_vld (head_vld),
    .head_sq  (head_sq),
    .op_lat   (op_lat),
    .iss_lat  (iss_lat),
    .ds_slots (ds_slots),
    .grant_o  (grant_o),
    .pop_o    (pop_o),
    .skip_o   (skip_o),
    .exec_o   (exec_o),
    .rel_o    (rel_o)
);

// File: tb/tb_issue_select.sv
`timescale 1ns/1ps
module tb_issue_select;

    localparam int NCLS = 4, WIDTH = 2, SEQW = 8, LATW = 3, NTHR = 2, BCW = 8;
    localparam int TIDW = 1, GW = 2, NBC = NCLS * NTHR, BMAX = (1 << BCW) - 1;
    localparam int NCYC = 3000;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic                     rst_n;
    logic [NCLS-1:0]          head_vld, head_sq, unit_free;
    logic [NCLS*SEQW-1:0]     head_seq;
    logic [NCLS*TIDW-1:0]     head_tid;
    logic [NCLS*LATW-1:0]     op_lat, iss_lat;
    logic [GW-1:0]            ds_slots;
    logic [NCLS-1:0]          grant_o, pop_o, skip_o, exec_o, rel_o;
    logic [GW-1:0]            n_grant_o;
    logic [NCLS*NTHR*BCW-1:0] busy_cnt_o;

    issue_select dut (.*);

    int total = 0, bad = 0;

    int  s_seq[NCLS], s_tid[NCLS], s_opl[NCLS], s_isl[NCLS], s_ds;
    bit  s_vld[NCLS], s_sq[NCLS], s_free[NCLS];

    int  m_tim[NCLS], m_busy[NBC], e_ng;
    bit  m_exec[NCLS], m_rel[NCLS], e_gr[NCLS], e_pop[NCLS], e_skip[NCLS];

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic bit unit_ok(input int c);
        return (c == 0) || (s_free[c] && m_tim[c] == 0);
    endfunction

    task automatic drive();
        for (int c = 0; c < NCLS; c++) begin
            head_vld[c]                 = s_vld[c];
            head_sq[c]                  = s_sq[c];
            unit_free[c]                = s_free[c];
            head_seq[c*SEQW +: SEQW]    = SEQW'(s_seq[c]);
            head_tid[c*TIDW +: TIDW]    = TIDW'(s_tid[c]);
            op_lat[c*LATW +: LATW]      = LATW'(s_opl[c]);
            iss_lat[c*LATW +: LATW]     = LATW'(s_isl[c]);
        end
        ds_slots = GW'(s_ds);
    endtask

    // Walk the valid heads oldest first and derive the expected grants.
    task automatic model_pick();
        bit seen[NCLS];
        int budget, used;
        bit done;
        budget = (s_ds < WIDTH) ? s_ds : WIDTH;
        used = 0;
        done = (budget == 0);
        e_ng = 0;
        for (int c = 0; c < NCLS; c++) begin
            seen[c] = 0; e_gr[c] = 0; e_pop[c] = 0; e_skip[c] = 0;
        end
        for (int step = 0; step < NCLS; step++) begin
            int best;
            best = -1;
            for (int c = 0; c < NCLS; c++)
                if (s_vld[c] && !seen[c] && (best < 0 || s_seq[c] < s_seq[best]))
                    best = c;
            if (best >= 0) begin
                seen[best] = 1;
                if (!done) begin
                    if (s_sq[best]) e_pop[best] = 1;
                    else if (unit_ok(best)) begin
                        e_gr[best] = 1; e_pop[best] = 1; used++;
                        if (used == budget) done = 1;
                    end else e_skip[best] = 1;
                end
            end
        end
        e_ng = used;
    endtask

    task automatic model_next();
        for (int c = 0; c < NCLS; c++) begin
            m_exec[c] = 0; m_rel[c] = 0;
            if (m_tim[c] > 0) begin
                if (m_tim[c] == 1) begin m_exec[c] = 1; m_rel[c] = 1; end
                m_tim[c]--;
            end
            if (e_gr[c]) begin
                if (c == 0) m_exec[c] = 1;
                else if (s_opl[c] <= 1 || s_isl[c] <= 1) begin
                    m_exec[c] = 1; m_rel[c] = 1;
                end else m_tim[c] = s_isl[c] - 1;
            end
            if (e_skip[c] && m_busy[c*NTHR + s_tid[c]] < BMAX)
                m_busy[c*NTHR + s_tid[c]]++;
        end
    endtask

    task automatic randomize_inputs();
        for (int c = 0; c < NCLS; c++) begin
            s_vld[c]  = ($urandom % 4) != 0;
            s_sq[c]   = ($urandom % 4) == 0;
            s_free[c] = ($urandom % 3) != 0;
            s_seq[c]  = int'($urandom % 64) * 4 + c;
            s_tid[c]  = int'($urandom % NTHR);
            s_opl[c]  = 1 + int'($urandom % 4);
            s_isl[c]  = 1 + int'($urandom % 4);
        end
        s_ds = int'($urandom % 4);
    endtask

    task automatic set_all(input bit v, input bit q, input bit f, input int ds);
        for (int c = 0; c < NCLS; c++) begin
            s_vld[c] = v; s_sq[c] = q; s_free[c] = f; s_tid[c] = 0;
            s_opl[c] = 1; s_isl[c] = 1; s_seq[c] = 40 - 10 * c;
        end
        s_ds = ds;
    endtask

    // Cycles 0..7 are directed corners; everything after is random.
    task automatic pick_inputs(input int i);
        randomize_inputs();
        case (i)
            0: set_all(1, 0, 1, 3);              // R2: classes 3 and 2 oldest
            1: set_all(1, 0, 1, 0);              // R8: no slots
            2: set_all(1, 1, 1, 1);              // R3: all squashed popped
            3: begin                             // R5: unit-less class, unit bit low
                set_all(0, 0, 0, 3); s_vld[0] = 1;
            end
            4: begin                             // R7: unpipelined grant
                set_all(0, 0, 1, 3); s_vld[2] = 1; s_opl[2] = 3; s_isl[2] = 3;
            end
            5, 6: begin                          // R7/R4: held class is skipped
                set_all(0, 0, 1, 3); s_vld[2] = 1; s_tid[2] = 1;
            end
            default: ;
        endcase
    endtask

    task automatic check_regs(input string tag);
        for (int c = 0; c < NCLS; c++) begin
            chk(exec_o[c] == m_exec[c], (m_tim[c] > 0 || tag == "R7") ? "R7 exec" : "R6 exec",
                int'(exec_o[c]), int'(m_exec[c]));
            chk(rel_o[c] == m_rel[c], (c == 0) ? "R5 rel" : "R6/R7 rel",
                int'(rel_o[c]), int'(m_rel[c]));
        end
        for (int b = 0; b < NBC; b++)
            chk(int'(busy_cnt_o[b*BCW +: BCW]) == m_busy[b], "R4 busy counter",
                int'(busy_cnt_o[b*BCW +: BCW]), m_busy[b]);
    endtask

    task automatic check_comb(input int i);
        for (int c = 0; c < NCLS; c++) begin
            chk(grant_o[c] == e_gr[c], (c == 0 && i == 3) ? "R5 grant" : "R2 grant",
                int'(grant_o[c]), int'(e_gr[c]));
            chk(pop_o[c] == e_pop[c], "R3 pop", int'(pop_o[c]), int'(e_pop[c]));
            chk(skip_o[c] == e_skip[c], "R4 skip", int'(skip_o[c]), int'(e_skip[c]));
            if (!s_vld[c])
                chk(!(pop_o[c] | skip_o[c] | grant_o[c]), "R9 invalid head", int'(pop_o[c]), 0);
        end
        chk(int'(n_grant_o) == e_ng, "R1 grant count", int'(n_grant_o), e_ng);
        if (s_ds == 0)
            chk(pop_o == '0 && skip_o == '0, "R8 no slots", int'(pop_o), 0);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0;
        set_all(0, 0, 0, 0);
        drive();
        for (int c = 0; c < NCLS; c++) begin m_tim[c] = 0; m_exec[c] = 0; m_rel[c] = 0; end
        for (int b = 0; b < NBC; b++) m_busy[b] = 0;
        repeat (3) @(negedge clk);
        set_all(1, 0, 1, 3);
        drive();
        @(negedge clk);
        // R10: registered outputs stay clear while reset is held
        chk(exec_o == '0, "R10 exec in reset", int'(exec_o), 0);
        chk(rel_o == '0, "R10 rel in reset", int'(rel_o), 0);
        chk(busy_cnt_o == '0, "R10 busy in reset", int'(busy_cnt_o[BCW-1:0]), 0);
        set_all(0, 0, 0, 0);
        drive();
        rst_n = 1'b1;
        for (int i = 0; i < NCYC; i++) begin
            @(negedge clk);
            check_regs((i == 7) ? "R7" : "");
            pick_inputs(i);
            drive();
            #1;
            model_pick();
            check_comb(i);
            model_next();
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (NCYC + 2000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule